// File: doc/BRIEF.md
# Banked Nibble Clock Register File

This block is the host-facing side of a real-time clock. A host sees sixteen 4-bit locations through an address, a write-data nibble, a write enable and a read enable. The top three locations always hold control state: a mode register, a test register and a reset/strobe register. The thirteen locations below them form a window. The window shows one of four banks, chosen by the two low bits of the mode register: the live time digits, the alarm digits with the hour-format and leap-year settings, or one of two general-purpose scratch banks.

Time digits are not stored here. Accesses to the time bank are passed straight to an external counter over a digit address, a write strobe and a read-data return. Alarm digits and both scratch banks are held locally. Writing the reset register produces one-cycle strobes for the divider reset and the alarm clear. The same register holds two enables for the periodic pulse outputs.

Top module: `rtc_bank_regfile`

## Requirements
- R1: After reset the mode register reads 0 (time bank, timer and alarm disabled), every alarm and scratch nibble reads 0, and all enables, strobes and `rdata_o` are 0.
- R2: Writing the mode register (address 13) stores the nibble. Bit 3 drives `timer_en_o`, bit 2 drives `alarm_en_o`, and bits [1:0] select the bank (0 time, 1 alarm/config, 2 scratch A, 3 scratch B). A read of address 13 returns the stored nibble.
- R3: In bank 0, an access to addresses 0..12 is passed to the counter. `tc_addr_o` equals `addr_i`, `tc_wdata_o` equals `wdata_i`, and `tc_we_o` is high in the same cycle as the write. A read returns `tc_rdata_i`.
- R4: Banks 2 and 3 each hold thirteen independent nibbles at addresses 0..12. A write in one bank leaves the other bank unchanged.
- R5: Bank 1 holds thirteen alarm/config nibbles that can be read back and are presented on `alarm_nib_o` (address k at bits [4k+3:4k]). Bit 0 of address 10 drives `hour24_o` (1 = 24-hour). Address 11 drives `leap_o`.
- R6: Addresses 13, 14 and 15 reach the control registers whichever bank is selected.
- R7: Writing address 15 with bit 1 set raises `div_rst_o` for exactly the one cycle after the write. `div_rst_o` is never high otherwise.
- R8: Writing address 15 with bit 0 set clears every bank-1 nibble except addresses 10 and 11, and raises `alarm_clr_o` for the one cycle after the write.
- R9: Bits 3 and 2 of a write to address 15 are stored and drive `pulse_1hz_en_o` and `pulse_16hz_en_o`. A read of address 15 returns those two bits with bits [1:0] as 0.
- R10: Address 14 stores a test nibble, presented on `test_o` and returned on read.
- R11: `rdata_o` updates on the clock edge that samples `re_i` and otherwise holds. A read and a write to the same location in the same cycle return the value from before the write.
- R12: `tc_we_o` is never high unless a write to addresses 0..12 takes place while bank 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write nibble |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 4 | Registered read nibble |
| tc_addr_o | output | 4 | Digit address to the time counter |
| tc_wdata_o | output | 4 | Digit write value to the time counter |
| tc_we_o | output | 1 | Digit write strobe to the time counter |
| tc_rdata_i | input | 4 | Digit read value from the time counter |
| timer_en_o | output | 1 | Timer enable (mode bit 3) |
| alarm_en_o | output | 1 | Alarm enable (mode bit 2) |
| hour24_o | output | 1 | 24-hour format selected |
| leap_o | output | 4 | Leap-year counter nibble |
| alarm_nib_o | output | 52 | All bank-1 nibbles, packed |
| div_rst_o | output | 1 | Divider reset strobe |
| alarm_clr_o | output | 1 | Alarm clear strobe |
| pulse_1hz_en_o | output | 1 | 1 Hz pulse output enable |
| pulse_16hz_en_o | output | 1 | 16 Hz pulse output enable |
| test_o | output | 4 | Test register nibble |

## Verification
`tc_we_o`, `tc_addr_o` and `tc_wdata_o` are combinational, so the bench samples them within the write cycle itself, before the edge. A read sampled at edge N appears on `rdata_o` after that edge. The scoreboard monitor pops the expected nibble at the falling edge after the capturing edge. Register-backed outputs (enables, `hour24_o`, `leap_o`, `test_o`) and both strobes become valid after the edge that takes the write. The bench therefore checks them just after that edge, and checks the strobes again one edge later to confirm they have dropped.

// File: rtl/rtc_rf_pkg.sv
package rtc_rf_pkg;
  typedef enum logic [1:0] {
    BANK_TIME  = 2'd0,
    BANK_ALARM = 2'd1,
    BANK_RAM_A = 2'd2,
    BANK_RAM_B = 2'd3
  } bank_e;
endpackage

// File: rtl/rtc_nibble_store.sv
module rtc_nibble_store #(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned DEPTH  = 13,
  parameter int unsigned ADDR_W = 4,
  parameter logic [DEPTH-1:0] KEEP = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NIB_W-1:0]         wdata_i,
  input  logic                     clr_i,
  output logic [DEPTH*NIB_W-1:0]   mem_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [NIB_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       q <= '0;
      else if (clr_i && !KEEP[i])        q <= '0;
      else if (we_i && addr_i == ADDR_W'(i)) q <= wdata_i;
    end
    assign mem_o[i*NIB_W +: NIB_W] = q;
  end
endmodule

// File: rtl/rtc_bank_decode.sv
module rtc_bank_decode
  import rtc_rf_pkg::*;
#(
  parameter int unsigned DEPTH  = 13,
  parameter int unsigned ADDR_W = 4
) (
  input  bank_e             bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              ctrl_sel_o,
  output logic              tc_we_o,
  output logic              alarm_we_o,
  output logic [1:0]        ram_we_o
);
  logic win;
  assign win        = addr_i < ADDR_W'(DEPTH);
  assign ctrl_sel_o = !win;

  always_comb begin
    tc_we_o    = 1'b0;
    alarm_we_o = 1'b0;
    ram_we_o   = '0;
    if (we_i && win) begin
      unique case (bank_i)
        BANK_TIME:  tc_we_o     = 1'b1;
        BANK_ALARM: alarm_we_o  = 1'b1;
        BANK_RAM_A: ram_we_o[0] = 1'b1;
        BANK_RAM_B: ram_we_o[1] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs #(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [NIB_W-1:0]  mode_o,
  output logic [NIB_W-1:0]  test_o,
  output logic [NIB_W-1:0]  rst_rd_o,
  output logic              clr_now_o,
  output logic              div_rst_o,
  output logic              alarm_clr_o,
  output logic              pulse_1hz_en_o,
  output logic              pulse_16hz_en_o
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(DEPTH + 2);

  logic wr_mode, wr_test, wr_rst;
  logic [1:0] pulse_q;

  assign wr_mode   = we_i && addr_i == A_MODE;
  assign wr_test   = we_i && addr_i == A_TEST;
  assign wr_rst    = we_i && addr_i == A_RST;
  assign clr_now_o = wr_rst && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= '0;
      test_o      <= '0;
      pulse_q     <= '0;
      div_rst_o   <= 1'b0;
      alarm_clr_o <= 1'b0;
    end else begin
      if (wr_mode) mode_o  <= wdata_i;
      if (wr_test) test_o  <= wdata_i;
      if (wr_rst)  pulse_q <= wdata_i[3:2];
      div_rst_o   <= wr_rst && wdata_i[1];
      alarm_clr_o <= clr_now_o;
    end
  end

  assign pulse_1hz_en_o  = pulse_q[1];
  assign pulse_16hz_en_o = pulse_q[0];
  assign rst_rd_o        = {pulse_q, {(NIB_W-2){1'b0}}};
endmodule

// File: rtl/rtc_bank_regfile.sv
module rtc_bank_regfile
  import rtc_rf_pkg::*;
#(
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned DEPTH     = 13,
  parameter int unsigned HOUR_ADDR = 10,
  parameter int unsigned LEAP_ADDR = 11,
  localparam int unsigned ADDR_W   = $clog2(DEPTH + 3)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NIB_W-1:0]       wdata_i,
  input  logic                   we_i,
  input  logic                   re_i,
  output logic [NIB_W-1:0]       rdata_o,
  output logic [ADDR_W-1:0]      tc_addr_o,
  output logic [NIB_W-1:0]       tc_wdata_o,
  output logic                   tc_we_o,
  input  logic [NIB_W-1:0]       tc_rdata_i,
  output logic                   timer_en_o,
  output logic                   alarm_en_o,
  output logic                   hour24_o,
  output logic [NIB_W-1:0]       leap_o,
  output logic [DEPTH*NIB_W-1:0] alarm_nib_o,
  output logic                   div_rst_o,
  output logic                   alarm_clr_o,
  output logic                   pulse_1hz_en_o,
  output logic                   pulse_16hz_en_o,
  output logic [NIB_W-1:0]       test_o
);
  localparam logic [DEPTH-1:0] KEEP_CFG =
    DEPTH'((1 << HOUR_ADDR) | (1 << LEAP_ADDR));
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(DEPTH + 1);

  logic [NIB_W-1:0] mode_q, rst_rd, rd_nib;
  logic             ctrl_sel, alarm_we, clr_now;
  logic [1:0]       ram_we;
  bank_e            bank;
  logic [DEPTH*NIB_W-1:0] ram_img [2];

  assign bank = bank_e'(mode_q[1:0]);

  rtc_bank_decode #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_decode (
    .bank_i     (bank),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .ctrl_sel_o (ctrl_sel),
    .tc_we_o    (tc_we_o),
    .alarm_we_o (alarm_we),
    .ram_we_o   (ram_we)
  );

  rtc_ctrl_regs #(.NIB_W(NIB_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .we_i            (we_i),
    .addr_i          (addr_i),
    .wdata_i         (wdata_i),
    .mode_o          (mode_q),
    .test_o          (test_o),
    .rst_rd_o        (rst_rd),
    .clr_now_o       (clr_now),
    .div_rst_o       (div_rst_o),
    .alarm_clr_o     (alarm_clr_o),
    .pulse_1hz_en_o  (pulse_1hz_en_o),
    .pulse_16hz_en_o (pulse_16hz_en_o)
  );

  rtc_nibble_store #(.NIB_W(NIB_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .KEEP(KEEP_CFG))
  i_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (alarm_we),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .clr_i   (clr_now),
    .mem_o   (alarm_nib_o)
  );

  for (genvar b = 0; b < 2; b++) begin : g_ram
    rtc_nibble_store #(.NIB_W(NIB_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .KEEP('0))
    i_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ram_we[b]),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .clr_i   (1'b0),
      .mem_o   (ram_img[b])
    );
  end

  assign tc_addr_o  = addr_i;
  assign tc_wdata_o = wdata_i;
  assign timer_en_o = mode_q[3];
  assign alarm_en_o = mode_q[2];
  assign hour24_o   = alarm_nib_o[HOUR_ADDR*NIB_W];
  assign leap_o     = alarm_nib_o[LEAP_ADDR*NIB_W +: NIB_W];

  always_comb begin
    rd_nib = '0;
    if (ctrl_sel) begin
      if (addr_i == A_MODE)      rd_nib = mode_q;
      else if (addr_i == A_TEST) rd_nib = test_o;
      else                       rd_nib = rst_rd;
    end else begin
      unique case (bank)
        BANK_TIME:  rd_nib = tc_rdata_i;
        BANK_ALARM: rd_nib = alarm_nib_o[int'(addr_i)*NIB_W +: NIB_W];
        BANK_RAM_A: rd_nib = ram_img[0][int'(addr_i)*NIB_W +: NIB_W];
        BANK_RAM_B: rd_nib = ram_img[1][int'(addr_i)*NIB_W +: NIB_W];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_nib;
  end
endmodule

// File: rtl/rtc_bank_regfile_chk.sv
module rtc_bank_regfile_chk #(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned DEPTH  = 13,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NIB_W-1:0]  wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [NIB_W-1:0]  rdata_o,
  input logic              tc_we_o,
  input logic              div_rst_o,
  input logic              alarm_clr_o,
  input logic              timer_en_o,
  input logic              alarm_en_o
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(DEPTH + 2);

  assert_tc_we_window_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_we_o |-> (we_i && addr_i < ADDR_W'(DEPTH)));

  assert_div_rst_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rst_o |-> $past(we_i && addr_i == A_RST && wdata_i[1]));

  assert_div_rst_fire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_RST && wdata_i[1]) |=> div_rst_o);

  assert_alarm_clr_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_clr_o |-> $past(we_i && addr_i == A_RST && wdata_i[0]));

  assert_mode_enables_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MODE) |=>
      (timer_en_o == $past(wdata_i[3]) && alarm_en_o == $past(wdata_i[2])));

  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

bind rtc_bank_regfile rtc_bank_regfile_chk #(
  .NIB_W(NIB_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .we_i        (we_i),
  .re_i        (re_i),
  .rdata_o     (rdata_o),
  .tc_we_o     (tc_we_o),
  .div_rst_o   (div_rst_o),
  .alarm_clr_o (alarm_clr_o),
  .timer_en_o  (timer_en_o),
  .alarm_en_o  (alarm_en_o)
);

// File: tb/test_rtc_bank_regfile.sv
module test_rtc_bank_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0, wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  rdata, tc_addr, tc_wdata, tc_rdata, leap, test_nib;
  logic        tc_we, timer_en, alarm_en, hour24, div_rst, alarm_clr, p1hz, p16hz;
  logic [51:0] alarm_nib;

  logic [3:0]  tc_mem [13];
  logic [3:0]  exp_q [$];
  string       tag_q [$];
  logic        re_seen = 1'b0;
  logic        s_tc_we;
  logic [3:0]  s_tc_addr, s_tc_wdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bank_regfile i_rtc_bank_regfile (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .tc_addr_o(tc_addr), .tc_wdata_o(tc_wdata), .tc_we_o(tc_we),
    .tc_rdata_i(tc_rdata), .timer_en_o(timer_en), .alarm_en_o(alarm_en),
    .hour24_o(hour24), .leap_o(leap), .alarm_nib_o(alarm_nib), .div_rst_o(div_rst),
    .alarm_clr_o(alarm_clr), .pulse_1hz_en_o(p1hz), .pulse_16hz_en_o(p16hz),
    .test_o(test_nib)
  );

  // time counter stand-in
  assign tc_rdata = (tc_addr < 4'd13) ? tc_mem[tc_addr] : 4'h0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < 13; i++) tc_mem[i] <= '0;
    else if (tc_we) tc_mem[tc_addr] <= tc_wdata;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [3:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    #1;
    s_tc_we = tc_we; s_tc_addr = tc_addr; s_tc_wdata = tc_wdata;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [3:0] e, string req);
    @(posedge clk); #1;
    addr = a; re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(posedge clk); #1;
    re = 1'b0;
  endtask

  task automatic rdwr(logic [3:0] a, logic [3:0] d, logic [3:0] e, string req);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1; re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(posedge clk); #1;
    we = 1'b0; re = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (re_seen) begin
      if (exp_q.size() == 0) check("R11 unexpected read", 1, 0);
      else check(tag_q.pop_front(), int'(rdata), int'(exp_q.pop_front()));
    end
    re_seen = re;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check("watchdog", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 timer_en", timer_en, 0);
    check("R1 alarm_en", alarm_en, 0);
    check("R1 rdata", rdata, 0);
    check("R1 pulses", {p1hz, p16hz}, 0);
    check("R1 hour24", hour24, 0);
    rd(4'd13, 4'h0, "R1 mode");
    wr(4'd13, 4'h2);
    rd(4'd5, 4'h0, "R1 ram");

    // R4 scratch banks, R12 no counter strobe
    wr(4'd0, 4'h5);
    check("R12 tc_we in ram bank", s_tc_we, 0);
    wr(4'd12, 4'hC);
    wr(4'd13, 4'h3);
    wr(4'd0, 4'h9);
    check("R12 tc_we in ram B", s_tc_we, 0);
    rd(4'd0, 4'h9, "R4 bank B");
    wr(4'd13, 4'h2);
    rd(4'd0, 4'h5, "R4 bank A kept");
    rd(4'd12, 4'hC, "R4 bank A top");

    // R2 mode enables, bank 0
    wr(4'd13, 4'hC);
    check("R2 timer_en", timer_en, 1);
    check("R2 alarm_en", alarm_en, 1);
    rd(4'd13, 4'hC, "R2 mode readback");

    // R3 time bank routed to counter
    wr(4'd3, 4'h7);
    check("R3 tc_we", s_tc_we, 1);
    check("R3 tc_addr", s_tc_addr, 3);
    check("R3 tc_wdata", s_tc_wdata, 7);
    rd(4'd3, 4'h7, "R3 read");
    wr(4'd13, 4'hC);
    check("R12 tc_we on ctrl write", s_tc_we, 0);
    rd(4'd14, 4'h0, "R6 test in bank 0");

    // R5 alarm/config bank
    wr(4'd13, 4'h1);
    wr(4'd10, 4'h1);
    check("R5 hour24", hour24, 1);
    wr(4'd11, 4'h2);
    check("R5 leap", leap, 2);
    wr(4'd4, 4'h6);
    check("R5 alarm_nib", alarm_nib[19:16], 6);
    rd(4'd4, 4'h6, "R5 alarm read");

    // R8 alarm clear, R9 pulse enables
    wr(4'd15, 4'hD);
    check("R8 alarm_clr high", alarm_clr, 1);
    check("R7 no div_rst", div_rst, 0);
    check("R9 p1hz", p1hz, 1);
    check("R9 p16hz", p16hz, 1);
    @(posedge clk); #1;
    check("R8 alarm_clr single", alarm_clr, 0);
    rd(4'd4, 4'h0, "R8 digit cleared");
    rd(4'd10, 4'h1, "R8 config kept");
    rd(4'd15, 4'hC, "R9 readback");

    // R7 divider reset
    wr(4'd15, 4'h2);
    check("R7 div_rst high", div_rst, 1);
    check("R8 no alarm_clr", alarm_clr, 0);
    check("R9 p1hz off", p1hz, 0);
    @(posedge clk); #1;
    check("R7 div_rst single", div_rst, 0);
    rd(4'd13, 4'h1, "R6 mode in bank 1");

    // R10 test register in bank 2
    wr(4'd13, 4'h2);
    wr(4'd14, 4'h6);
    check("R10 test_o", test_nib, 6);
    rd(4'd14, 4'h6, "R10 readback");

    // R11 read-before-write and hold
    wr(4'd1, 4'h3);
    rdwr(4'd1, 4'hF, 4'h3, "R11 old value");
    rd(4'd1, 4'hF, "R11 new value");
    repeat (3) @(posedge clk); #1;
    check("R11 hold", rdata, 4'hF);
    check("R11 queue drained", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule